// File: doc/BRIEF.md
# Single-Cycle Multiply-Accumulate Unit

This unit multiplies two 32-bit operands into a full 64-bit product and keeps the result in an accumulator. The accumulator is split into an upper word (HI) and a lower word (LO). One operation is accepted per clock while the valid strobe is high. An operation either replaces the accumulator with the product or adds the product to it. Operands are read as signed or unsigned, as the operation code selects. Sums wrap modulo 2^64.

A three-operand multiply form writes the product to the accumulator. It also returns the low product word on a destination-result port, with a write enable that a register file can use directly. Two independent move-to ports load HI and LO directly. They are used for context restore or to preload an accumulation.

Top module: `mac_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, HI and LO read zero, the destination write enable is low and the destination data is zero.
- R2: Operation code 1 (unsigned multiply) with valid high sets {HI,LO} to the zero-extended 64-bit product of the operands. The new value is visible on the outputs after the next rising clock edge.
- R3: Operation code 0 (signed multiply) sets {HI,LO} to the 64-bit two's-complement product of the operands, each read as a signed value.
- R4: Operation code 2 (signed multiply-add) adds the signed 64-bit product to the current {HI,LO} and stores the sum in {HI,LO}.
- R5: Operation code 3 (unsigned multiply-add) adds the unsigned 64-bit product to the current {HI,LO} and stores the sum in {HI,LO}.
- R6: Operation codes 4 (signed) and 5 (unsigned) are the three-operand multiply. Each sets {HI,LO} to the product. After the same edge it raises the destination write enable for exactly one cycle and places the low product word on the destination data port.
- R7: The destination write enable stays low after any cycle that does not carry a valid three-operand multiply. Between such operations the destination data holds its last value.
- R8: Operations given on consecutive cycles each take effect on their own edge: one per clock, with no stall cycles.
- R9: The move-to-HI enable loads the HI data into HI on the next edge, and the move-to-LO enable loads the LO data into LO on the next edge. Each leaves the other half unchanged.
- R10: When a move-to write and a valid operation fall in the same cycle, the move-to write sets its own half. The other half takes the operation's result.
- R11: Operation codes 6 and 7, and any cycle with valid low, leave HI, LO and the destination port unchanged.
- R12: Multiply-add overflow wraps modulo 2^64 with no flag or saturation: for example, all-ones plus a product of 1 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation selector (see R2 to R6, R11) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| hi_wr_en | input | 1 | Move-to-HI enable |
| hi_wr_data | input | 32 | Move-to-HI data |
| lo_wr_en | input | 1 | Move-to-LO enable |
| lo_wr_data | input | 32 | Move-to-LO data |
| hi_q | output | 32 | Accumulator upper word |
| lo_q | output | 32 | Accumulator lower word |
| dst_data | output | 32 | Three-operand result word |
| dst_we | output | 1 | Destination write enable, one-cycle pulse |

## Verification
The bench aims at the sign boundaries. With all-ones operands, a design that mixes up sign- and zero-extension gives 1 where FFFFFFFE_00000001 is due, or the reverse. An accumulation that starts from all-ones and overflows exposes a design that saturates or drops the carry from LO into HI. Move-to writes that collide with an operation catch a design that lets the wrong source win, or that clobbers the untouched half. Back-to-back multiply-adds and three-operand pulses catch stale accumulator feedback and a write enable that stays high for more than one cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S   = 3'd0,
    OP_MUL_U   = 3'd1,
    OP_MADD_S  = 3'd2,
    OP_MADD_U  = 3'd3,
    OP_MUL3_S  = 3'd4,
    OP_MUL3_U  = 3'd5
  } mac_op_e;

  typedef struct packed {
    logic active;
    logic is_signed;
    logic accumulate;
    logic to_dst;
  } mac_ctl_t;

  function automatic mac_ctl_t mac_decode(input logic valid, input logic [2:0] code);
    mac_ctl_t c;
    c = '0;
    case (code)
      OP_MUL_S:  c = '{active: 1'b1, is_signed: 1'b1, accumulate: 1'b0, to_dst: 1'b0};
      OP_MUL_U:  c = '{active: 1'b1, is_signed: 1'b0, accumulate: 1'b0, to_dst: 1'b0};
      OP_MADD_S: c = '{active: 1'b1, is_signed: 1'b1, accumulate: 1'b1, to_dst: 1'b0};
      OP_MADD_U: c = '{active: 1'b1, is_signed: 1'b0, accumulate: 1'b1, to_dst: 1'b0};
      OP_MUL3_S: c = '{active: 1'b1, is_signed: 1'b1, accumulate: 1'b0, to_dst: 1'b1};
      OP_MUL3_U: c = '{active: 1'b1, is_signed: 1'b0, accumulate: 1'b0, to_dst: 1'b1};
      default:   c = '0;
    endcase
    if (!valid) c = '0;
    return c;
  endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  output logic [PROD_W-1:0] prod
);

  // Widen an operand to the product width, by sign or by zero.
  function automatic logic [PROD_W-1:0] widen(input logic [DATA_W-1:0] v, input logic sgn);
    return {{DATA_W{sgn & v[DATA_W-1]}}, v};
  endfunction

  // The low PROD_W bits of the widened product are the exact product.
  always_comb prod = widen(a, is_signed) * widen(b, is_signed);

endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              accumulate,
  input  logic [PROD_W-1:0] prod,
  input  logic              hi_wr_en,
  input  logic [DATA_W-1:0] hi_wr_data,
  input  logic              lo_wr_en,
  input  logic [DATA_W-1:0] lo_wr_data,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] arith_lo
);

  logic [PROD_W-1:0] arith_res;

  function automatic logic [PROD_W-1:0] acc_step(input logic [PROD_W-1:0] cur,
                                                 input logic [PROD_W-1:0] p,
                                                 input logic              add);
    return add ? (cur + p) : p;
  endfunction

  always_comb begin
    arith_res = acc_step({hi_q, lo_q}, prod, accumulate);
    arith_lo  = arith_res[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_wr_en)    hi_q <= hi_wr_data;
      else if (active) hi_q <= arith_res[PROD_W-1:DATA_W];
      if (lo_wr_en)    lo_q <= lo_wr_data;
      else if (active) lo_q <= arith_res[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/mac_dst.sv
module mac_dst #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              to_dst,
  input  logic [DATA_W-1:0] arith_lo,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_we
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_data <= '0;
      dst_we   <= 1'b0;
    end else begin
      dst_we <= to_dst;
      if (to_dst) dst_data <= arith_lo;
    end
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              hi_wr_en,
  input  logic [DATA_W-1:0] hi_wr_data,
  input  logic              lo_wr_en,
  input  logic [DATA_W-1:0] lo_wr_data,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_we
);
  import mac_pkg::*;

  mac_ctl_t          ctl;
  logic [PROD_W-1:0] mult_prod;
  logic [DATA_W-1:0] arith_lo;

  always_comb ctl = mac_decode(op_valid, op_code);

  mac_mult #(.DATA_W(DATA_W)) mult_i (
    .a         (opnd_a),
    .b         (opnd_b),
    .is_signed (ctl.is_signed),
    .prod      (mult_prod)
  );

  mac_acc #(.DATA_W(DATA_W)) acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (ctl.active),
    .accumulate (ctl.accumulate),
    .prod       (mult_prod),
    .hi_wr_en   (hi_wr_en),
    .hi_wr_data (hi_wr_data),
    .lo_wr_en   (lo_wr_en),
    .lo_wr_data (lo_wr_data),
    .hi_q       (hi_q),
    .lo_q       (lo_q),
    .arith_lo   (arith_lo)
  );

  mac_dst #(.DATA_W(DATA_W)) dst_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .to_dst   (ctl.to_dst),
    .arith_lo (arith_lo),
    .dst_data (dst_data),
    .dst_we   (dst_we)
  );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              hi_wr_en,
  input logic [DATA_W-1:0] hi_wr_data,
  input logic              lo_wr_en,
  input logic [DATA_W-1:0] lo_wr_data,
  input logic [DATA_W-1:0] hi_q,
  input logic [DATA_W-1:0] lo_q,
  input logic [DATA_W-1:0] dst_data,
  input logic              dst_we,
  input logic [PROD_W-1:0] mult_prod
);

  logic is_mul3, is_madd, is_quiet;
  always_comb begin
    is_mul3  = op_valid && (op_code[2:1] == 2'b10);
    is_madd  = op_valid && (op_code[2:1] == 2'b01);
    is_quiet = (!op_valid || op_code[2:1] == 2'b11) && !hi_wr_en && !lo_wr_en;
  end

  // R6
  mul3_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mul3 |=> dst_we);

  // R7
  dst_we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mul3 |=> !dst_we);

  // R6
  dst_matches_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mul3 && !lo_wr_en |=> dst_data == lo_q);

  // R11
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_quiet |=> $stable(hi_q) && $stable(lo_q) && $stable(dst_data));

  // R9
  move_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_en |=> hi_q == $past(hi_wr_data));

  // R9
  move_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_en |=> lo_q == $past(lo_wr_data));

  // R4
  madd_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_madd && !hi_wr_en && !lo_wr_en |=>
      {hi_q, lo_q} == $past({hi_q, lo_q}) + $past(mult_prod));

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .hi_wr_en   (hi_wr_en),
  .hi_wr_data (hi_wr_data),
  .lo_wr_en   (lo_wr_en),
  .lo_wr_data (lo_wr_data),
  .hi_q       (hi_q),
  .lo_q       (lo_q),
  .dst_data   (dst_data),
  .dst_we     (dst_we),
  .mult_prod  (mult_prod)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        hi_wr_en = 1'b0, lo_wr_en = 1'b0;
  logic [31:0] hi_wr_data = '0, lo_wr_data = '0;
  logic [31:0] hi_q, lo_q, dst_data;
  logic        dst_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .hi_q(hi_q), .lo_q(lo_q), .dst_data(dst_data), .dst_we(dst_we)
  );

  typedef struct {
    logic [63:0] acc;
    logic        we;
    logic [31:0] dd;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] m_acc = '0;
  logic [31:0] m_dd = '0;

  // Model: products through 64-bit integer arithmetic.
  function automatic logic [63:0] ref_prod(logic [31:0] a, logic [31:0] b, bit sgn);
    longint sp;
    longint unsigned up;
    if (sgn) begin
      sp = longint'(int'(a)) * longint'(int'(b));
      return sp;
    end
    up = longint'({32'd0, a}) * longint'({32'd0, b});
    return up;
  endfunction

  task automatic drive(bit v, logic [2:0] code, logic [31:0] a, logic [31:0] b,
                       bit hwe, logic [31:0] hd, bit lwe, logic [31:0] ld, string tag);
    exp_t e;
    logic [63:0] res;
    bit known;
    @(negedge clk);
    op_valid = v; op_code = code; opnd_a = a; opnd_b = b;
    hi_wr_en = hwe; hi_wr_data = hd; lo_wr_en = lwe; lo_wr_data = ld;
    known = v && (code <= 3'd5);
    res = m_acc;
    e.we = 1'b0;
    if (known) begin
      case (code)
        3'd0, 3'd4: res = ref_prod(a, b, 1'b1);
        3'd1, 3'd5: res = ref_prod(a, b, 1'b0);
        3'd2:       res = m_acc + ref_prod(a, b, 1'b1);
        default:    res = m_acc + ref_prod(a, b, 1'b0);
      endcase
      if (code == 3'd4 || code == 3'd5) begin
        e.we = 1'b1;
        m_dd = res[31:0];
      end
    end
    if (hwe) res[63:32] = hd;
    if (lwe) res[31:0]  = ld;
    m_acc = res;
    e.acc = res; e.dd = m_dd; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(string tag);
    drive(1'b0, 3'd0, 32'd0, 32'd0, 1'b0, 32'd0, 1'b0, 32'd0, tag);
  endtask

  // Monitor: one result per edge, sampled 1 ns after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if ({hi_q, lo_q} !== e.acc || dst_we !== e.we || dst_data !== e.dd) begin
          errors++;
          $display("FAIL %s: hi/lo=%h we=%b dst=%h expected hi/lo=%h we=%b dst=%h",
                   e.tag, {hi_q, lo_q}, dst_we, dst_data, e.acc, e.we, e.dd);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (hi_q !== 0 || lo_q !== 0 || dst_we !== 0 || dst_data !== 0) begin
      errors++;
      $display("FAIL R1: hi=%h lo=%h we=%b dst=%h expected all zero", hi_q, lo_q, dst_we, dst_data);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 after reset");

    // R2 unsigned extreme
    drive(1, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2");
    drive(1, 3'd1, 32'h8000_0000, 32'd2, 0, 0, 0, 0, "R2");
    // R3 signed
    drive(1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3");
    drive(1, 3'd0, 32'hFFFF_FFFD, 32'd5, 0, 0, 0, 0, "R3");
    // R4 signed accumulate, R5 unsigned accumulate
    drive(1, 3'd2, 32'hFFFF_FFFF, 32'd7, 0, 0, 0, 0, "R4");
    drive(1, 3'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0, "R4");
    drive(1, 3'd3, 32'hFFFF_FFFF, 32'd3, 0, 0, 0, 0, "R5");
    // R12 wrap from all ones
    drive(0, 3'd0, 0, 0, 1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, "R9 preload");
    drive(1, 3'd3, 32'd1, 32'd1, 0, 0, 0, 0, "R12");
    drive(1, 3'd2, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, "R12");
    // R6 three-operand, then R7 pulse ends
    drive(1, 3'd4, 32'hFFFF_FFFE, 32'h0001_0003, 0, 0, 0, 0, "R6");
    idle("R7");
    drive(1, 3'd5, 32'hDEAD_BEEF, 32'h0000_0100, 0, 0, 0, 0, "R6");
    drive(1, 3'd5, 32'h0000_0011, 32'h0000_0011, 0, 0, 0, 0, "R6");
    drive(1, 3'd1, 32'd9, 32'd9, 0, 0, 0, 0, "R7");
    // R9 independent halves
    drive(0, 3'd0, 0, 0, 1, 32'hA5A5_0001, 0, 0, "R9");
    drive(0, 3'd0, 0, 0, 0, 0, 1, 32'h5A5A_0002, "R9");
    // R10 collisions
    drive(1, 3'd1, 32'd1000, 32'd1000, 0, 0, 1, 32'hCAFE_0000, "R10");
    drive(1, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 32'h0000_1111, 0, 0, "R10");
    drive(1, 3'd4, 32'd3, 32'd4, 0, 0, 1, 32'h0BAD_0BAD, "R10");
    // R11 ignored codes and strobe low
    drive(1, 3'd6, 32'hFFFF_FFFF, 32'd2, 0, 0, 0, 0, "R11");
    drive(1, 3'd7, 32'd5, 32'd5, 0, 0, 0, 0, "R11");
    drive(0, 3'd4, 32'd5, 32'd5, 0, 0, 0, 0, "R11");
    // R8 back-to-back mixed stream
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; a = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; b = lfsr;
      drive(1, 3'(i % 6), a, b, 0, 0, 0, 0, "R8");
    end
    idle("R8 tail");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule